// File: doc/BRIEF.md
# USB Host Receive Error Status

This block watches the receive side of a USB host during one token transaction and reports what went wrong in a five-bit status register. The transaction begins with a start strobe. A bit-time timeout window then opens and waits for a packet start. Payload bits arrive already NRZI-decoded, one per valid strobe, between a packet-start and a packet-end strobe. The stream runs from the first data bit up to and including the 16-bit CRC. The PID has already been removed, and its toggle value is presented on a separate input.

While the transaction runs, the block drops stuffed zeros and counts ones runs. It accumulates a CRC16 over the payload plus CRC, counts payload bits, and notes any SE0 inside the packet. A single end-of-transaction strobe then loads all five result bits together. Software reads the register. It clears a bit by writing zero to that position, and a one leaves that bit unchanged. A bit that software never clears is simply replaced by the next transaction's result.

Top module: `usb_rx_errstat`

## Requirements
- R1: Status bit 0 (stuffing) is set when seven consecutive one-bits are received in a packet. Six ones followed by a zero is legal: that zero is discarded and is neither counted nor fed to the CRC.
- R2: On an IN transaction that received a packet, status bit 1 (toggle) is set when `pkt_tgl` differs from `exp_tgl`.
- R3: On an IN transaction that received a packet, status bit 2 (CRC) is set when the CRC16 remainder differs from 0x800D. The CRC uses polynomial x^16+x^15+x^2+1, is preset to all ones at packet start, and takes bits in arrival order, least significant bit of each byte first. A packet ends with the complemented CRC, sent from its most significant bit down.
- R4: Status bit 3 (timeout) is set in any of three cases. The first is `tmo_limit` ticks passing after `txn_start` with no `pkt_sop`. The second is SE0 seen inside a packet before `pkt_eop`. The third is a stuffing error.
- R5: Status bit 4 (overrun) is set when a received packet carries more payload bytes than `max_bytes`, where payload excludes the 16 CRC bits. Exactly `max_bytes` bytes is not an error.
- R6: A write sets each status bit whose `wr_data` bit is 0 to zero and leaves the bits written with 1 unchanged. No bit ever rises except at `txn_end`.
- R7: `txn_end` loads all five bits at once, overwriting any bits left set. Without `txn_end` or a write, the register holds its value.
- R8: After reset the status register reads zero.
- R9: On a transaction that is not IN, the toggle and CRC bits load as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| txn_start | input | 1 | Transaction start; clears per-transaction state and opens the timeout window |
| tick | input | 1 | Bit-time tick for the timeout count |
| tmo_limit | input | TW | Ticks allowed before a packet must start |
| pkt_sop | input | 1 | Packet start (SYNC detected) |
| pkt_eop | input | 1 | Packet end |
| rx_valid | input | 1 | Received bit strobe |
| rx_bit | input | 1 | Decoded received bit |
| rx_se0 | input | 1 | SE0 seen on the line |
| is_in | input | 1 | Current transaction is IN |
| exp_tgl | input | 1 | Expected data toggle |
| pkt_tgl | input | 1 | Toggle carried by the received data PID |
| max_bytes | input | MAXW | Endpoint maximum packet size in bytes |
| txn_end | input | 1 | End of transaction; loads the status bits |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 5 | Write data; 0 clears the matching bit |
| status | output | 5 | {overrun, timeout, crc, toggle, stuffing} |

## Verification
The properties assume that `txn_end` only follows a finished transaction and that `is_in` is stable while it is asserted. They also assume that software writes and `txn_end` never coincide, since the end strobe has priority. The stimulus drives every control input on falling edges and holds `is_in`, `exp_tgl`, `pkt_tgl` and `max_bytes` from transaction start to its end. It issues writes only between transactions. The bench inserts stuffed zeros itself after each run of six ones, except in the one case that injects a deliberate run of seven.

// File: rtl/usb_rx_errstat.sv
module usb_rx_errstat #(
  parameter int MAXW = 11,
  parameter int TW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            txn_start,
  input  logic            tick,
  input  logic [TW-1:0]   tmo_limit,
  input  logic            pkt_sop,
  input  logic            pkt_eop,
  input  logic            rx_valid,
  input  logic            rx_bit,
  input  logic            rx_se0,
  input  logic            is_in,
  input  logic            exp_tgl,
  input  logic            pkt_tgl,
  input  logic [MAXW-1:0] max_bytes,
  input  logic            txn_end,
  input  logic            wr_en,
  input  logic [4:0]      wr_data,
  output logic [4:0]      status
);
  localparam int BW = MAXW + 4;
  localparam logic [15:0] RESID = 16'h800D;
  localparam logic [15:0] POLY  = 16'h8005;

  logic [2:0]    ones;
  logic [BW-1:0] bits;
  logic [15:0]   crc;
  logic [TW-1:0] tcnt;
  logic armed, tmo_hit, in_pkt, got_pkt, stf, se0_bad;

  wire stuffed0 = rx_valid && in_pkt && !rx_bit && (ones == 3'd6);
  wire fb = crc[15] ^ rx_bit;
  wire [15:0] crc_nx = {crc[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
  wire [BW-1:0] lim = {1'b0, max_bytes, 3'b000} + BW'(16);
  wire overrun = got_pkt && (bits > lim);

  wire [4:0] fresh = {overrun,
                      stf | se0_bad | tmo_hit,
                      is_in && got_pkt && (crc != RESID),
                      is_in && got_pkt && (pkt_tgl != exp_tgl),
                      stf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones <= '0; bits <= '0; crc <= '1; tcnt <= '0;
      armed <= 1'b0; tmo_hit <= 1'b0; in_pkt <= 1'b0;
      got_pkt <= 1'b0; stf <= 1'b0; se0_bad <= 1'b0;
    end else if (txn_start) begin
      armed <= 1'b1; tcnt <= '0; tmo_hit <= 1'b0; in_pkt <= 1'b0;
      got_pkt <= 1'b0; stf <= 1'b0; se0_bad <= 1'b0;
    end else begin
      if (armed && tick) begin
        if (tcnt == tmo_limit - TW'(1)) begin
          tmo_hit <= 1'b1;
          armed   <= 1'b0;
        end else begin
          tcnt <= tcnt + TW'(1);
        end
      end
      if (pkt_sop) begin
        in_pkt <= 1'b1; got_pkt <= 1'b1; armed <= 1'b0;
        crc <= '1; bits <= '0; ones <= '0;
      end else if (pkt_eop) begin
        in_pkt <= 1'b0;
      end else if (in_pkt) begin
        if (rx_se0) se0_bad <= 1'b1;
        if (rx_valid) begin
          if (rx_bit) begin
            if (ones == 3'd6) stf <= 1'b1;
            else ones <= ones + 3'd1;
          end else begin
            ones <= '0;
          end
          if (!stuffed0) begin
            crc <= crc_nx;
            if (bits != '1) bits <= bits + BW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status <= '0;
    else if (txn_end) status <= fresh;
    else if (wr_en)   status <= status & wr_data;
  end
endmodule

module usb_rx_errstat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txn_end,
  input logic       wr_en,
  input logic       is_in,
  input logic [4:0] status
);
  AST_NO_RISE_WITHOUT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_end |=> ((status & ~$past(status)) == 5'b0)); // R6
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_end && !wr_en) |=> $stable(status)); // R7
  AST_STUFF_IMPLIES_TOUT: assert property (@(posedge clk) disable iff (!rst_n)
    txn_end |=> (!status[0] || status[3])); // R4
  AST_OUT_MASKS_IN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && !is_in) |=> (status[2:1] == 2'b00)); // R9
endmodule

bind usb_rx_errstat usb_rx_errstat_chk u_chk (.*);

// File: tb/sim_usb_rx_errstat.sv
module sim_usb_rx_errstat;
  localparam int LIM = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_start = 0, tick = 0, pkt_sop = 0, pkt_eop = 0, rx_valid = 0, rx_bit = 0, rx_se0 = 0;
  logic is_in = 0, exp_tgl = 0, pkt_tgl = 0, txn_end = 0, wr_en = 0;
  logic [7:0] tmo_limit = 8'(LIM);
  logic [10:0] max_bytes = 11'd8;
  logic [4:0] wr_data = '0;
  logic [4:0] status;
  int total = 0, bad = 0, run = 0;
  logic [4:0] expq[$];
  string tagq[$];
  bit finished = 0;

  always #5 clk = ~clk;

  usb_rx_errstat u0 (.*);

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: status=%b expected=%b", tag, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    if (txn_end) begin
      @(negedge clk);
      if (expq.size() == 0) check(status, 5'bxxxxx, "scoreboard empty");
      else check(status, expq.pop_front(), tagq.pop_front());
    end
  end

  task automatic sbit(input logic b, input bit raw);
    @(negedge clk); rx_valid = 1; rx_bit = b;
    if (!raw) begin
      if (b) begin
        run++;
        if (run == 6) begin @(negedge clk); rx_bit = 0; run = 0; end
      end else run = 0;
    end
  endtask

  task automatic txn(input bit in_v, input bit et, input bit pt, input int nb,
                     input bit bad_crc, input bit tmo, input bit se0, input bit inj,
                     input logic [10:0] mx, input string tag);
    logic [15:0] crc = 16'hFFFF;
    logic [4:0] e;
    bit got = !tmo;
    e[0] = inj;
    e[1] = in_v && got && (et != pt);
    e[2] = in_v && got && bad_crc;
    e[3] = tmo || se0 || inj;
    e[4] = got && (nb > int'(mx));
    expq.push_back(e); tagq.push_back(tag);
    @(negedge clk); is_in = in_v; exp_tgl = et; pkt_tgl = pt; max_bytes = mx; txn_start = 1;
    @(negedge clk); txn_start = 0;
    repeat (tmo ? LIM + 3 : 3) begin
      tick = 1; @(negedge clk); tick = 0; @(negedge clk);
    end
    if (!tmo) begin
      pkt_sop = 1; @(negedge clk); pkt_sop = 0; run = 0;
      if (inj) begin repeat (7) sbit(1, 1); sbit(0, 1); end
      for (int i = 0; i < nb; i++) begin
        logic [7:0] by = (i % 3 == 0) ? 8'hFF : 8'((i * 37 + nb * 11) & 255);
        for (int b = 0; b < 8; b++) begin
          logic fbk = crc[15] ^ by[b];
          crc = {crc[14:0], 1'b0} ^ (fbk ? 16'h8005 : 16'h0000);
          sbit((bad_crc && i == 0 && b == 0) ? ~by[b] : by[b], 0);
        end
      end
      if (se0) begin @(negedge clk); rx_valid = 0; rx_se0 = 1; @(negedge clk); rx_se0 = 0; end
      for (int k = 15; k >= 0; k--) sbit(~crc[k], 0);
      @(negedge clk); rx_valid = 0; pkt_eop = 1;
      @(negedge clk); pkt_eop = 0;
    end
    @(negedge clk); txn_end = 1;
    @(negedge clk); txn_end = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic swr(input logic [4:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(status, 5'b00000, "R8 reset value");
    rst_n = 1;
    @(negedge clk);
    check(status, 5'b00000, "R8 after reset release");
    txn(1, 0, 0, 4, 0, 0, 0, 0, 11'd8, "R1 R3 clean IN with stuffed runs");
    txn(1, 1, 0, 3, 0, 0, 0, 0, 11'd8, "R2 toggle mismatch");
    txn(1, 1, 1, 3, 1, 0, 0, 0, 11'd8, "R3 R7 crc error overwrites toggle");
    txn(1, 0, 0, 0, 0, 1, 0, 0, 11'd8, "R4 timeout, no packet");
    txn(0, 0, 0, 2, 0, 0, 1, 0, 11'd8, "R4 SE0 inside packet");
    txn(0, 0, 0, 2, 0, 0, 0, 1, 11'd8, "R1 R4 seven ones");
    txn(1, 0, 0, 8, 0, 0, 0, 0, 11'd8, "R5 size equal to max");
    txn(1, 0, 0, 9, 0, 0, 0, 0, 11'd8, "R5 size above max");
    txn(0, 0, 1, 3, 1, 0, 0, 0, 11'd8, "R9 OUT masks toggle and crc");
    txn(1, 1, 0, 10, 1, 0, 0, 0, 11'd8, "R2 R3 R5 combined");
    swr(5'b11101);
    check(status, 5'b10100, "R6 zero clears toggle bit");
    swr(5'b11111);
    check(status, 5'b10100, "R6 ones leave bits alone");
    repeat (5) @(negedge clk);
    check(status, 5'b10100, "R7 hold while idle");
    swr(5'b00000);
    check(status, 5'b00000, "R6 clear all");
    txn(1, 0, 0, 5, 0, 0, 0, 0, 11'd8, "R1 R3 clean after clear");
    if (expq.size() != 0) check(5'b0, 5'b1, "scoreboard leftovers");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule